// File: doc/BRIEF.md
# Bus-Width Steering Data Buffer with Paired-Word Read Latch

This block sits between a 32-bit processor data path and two places it can reach. One is a main memory built from two interleaved 32-bit banks. The other is an I/O bus whose devices may be 8, 16 or 32 bits wide. The processor always sees a complete 32-bit word on its fixed byte lanes, and the buffer does the work of filling those lanes correctly.

A memory read that misses fetches both banks in one memory cycle and keeps the 64-bit result. A later read of either word of that pair is answered from the held copy after one cycle, with no memory cycle at all. A memory write to either word of the held pair throws the copy away. An I/O access to a narrow device is broken into a series of narrow transfers. Each transfer's data is moved from the device's low lanes to the lane the processor expects, and the processor's ready comes only after the last transfer.

The processor raises `cpu_req` for one cycle while the buffer is idle, which is at any time after it has seen `cpu_rdy`, and holds no further request until the next `cpu_rdy`. Arbitration and DRAM timing are outside this block. The memory side gets a fixed window of `MEM_WAIT` cycles, and each I/O transfer gets `IO_WAIT` cycles.

Top module: `dbuf_bus_bridge`

## Requirements
- R1: During and after reset, `cpu_rdy`, `mem_cyc` and `io_cyc` are low and no pair is held, so the first memory read is a miss.
- R2: A memory read miss drives `mem_cyc` for exactly `MEM_WAIT` cycles with `mem_addr` equal to the request word address. On the cycle `MEM_WAIT`+1 after the request, `cpu_rdy` rises with the word of bank 1 when address bit 2 is 1 and of bank 0 when it is 0. Both bank words are taken from `mem_rdata0`/`mem_rdata1` on the last window cycle.
- R3: A memory read whose address bits 31:3 match the held pair raises `cpu_rdy` in the cycle after the request, with the held word picked by address bit 2, and raises no `mem_cyc`.
- R4: A read miss to a different pair replaces the held pair, so a read of the old pair that follows is a miss again.
- R5: A memory write drives `mem_cyc` with `mem_we`, `mem_addr`, `mem_be` and `mem_wdata` equal to the request for `MEM_WAIT` cycles, and answers `MEM_WAIT`+1 cycles after the request. It drops the held pair when its bits 31:3 match that pair and leaves the held pair untouched otherwise.
- R6: With `cpu_size` = 00 (8-bit device), there is one transfer per enabled byte, in ascending lane order. `io_addr[1:0]` equals the lane number. The device byte on `io_rdata[7:0]` goes to that lane, and the lanes whose byte enable is clear read as zero.
- R7: With `cpu_size` = 01 (16-bit device), there is one transfer for each half-word that has an enabled byte, lower half first. `io_addr[1:0]` is 00 or 10, and `io_rdata[15:0]` goes to that half's two lanes, masked by the byte enables.
- R8: With `cpu_size` = 10 or 11 (32-bit device), there is a single transfer at `io_addr[1:0]` = 00, and `io_rdata` is passed through and masked by the byte enables.
- R9: Each transfer holds `io_cyc` for `IO_WAIT` cycles and the transfers run back to back, with `io_addr[31:2]` fixed. `cpu_rdy` rises in the cycle `io_cyc` falls, n·`IO_WAIT`+1 cycles after the request, where n is the number of transfers.
- R10: On an I/O write, `io_we` is high throughout, and `io_wdata` carries the processor bytes of the current transfer shifted down to the device's low lanes.
- R11: I/O accesses neither fill nor drop the held pair.
- R12: `mem_cyc` and `io_cyc` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | One-cycle request strobe, taken while idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_io | input | 1 | 1 = I/O bus access, 0 = memory access |
| cpu_size | input | 2 | I/O device width: 00 8-bit, 01 16-bit, 10/11 32-bit |
| cpu_addr | input | 30 | Word address, bits 31:2 |
| cpu_be | input | 4 | Byte enables, bit i for lane i |
| cpu_wdata | input | 32 | Write data on processor lanes |
| cpu_rdata | output | 32 | Read data on processor lanes, valid with cpu_rdy |
| cpu_rdy | output | 1 | One-cycle completion strobe |
| mem_cyc | output | 1 | Memory cycle window |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 30 | Memory word address; bit 2 picks the bank on writes |
| mem_be | output | 4 | Memory byte enables |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata0 | input | 32 | Bank 0 word of the addressed pair |
| mem_rdata1 | input | 32 | Bank 1 word of the addressed pair |
| io_cyc | output | 1 | I/O transfer window |
| io_we | output | 1 | I/O write |
| io_addr | output | 32 | Byte address of the current transfer |
| io_wdata | output | 32 | Write data steered to device lanes |
| io_rdata | input | 32 | Device data on its low lanes |

## Verification
A held pair that is wrongly marked valid shows up as a read that completes one cycle after the request with a stale word and no `mem_cyc`. A pair wrongly dropped or never filled shows up as a `MEM_WAIT`+1 latency and a memory window where one cycle was due. Both are visible on the very access that follows the faulty fill or write. A wrong pending-lane mask or wrong steering shows up within that same I/O access. The symptom is an extra or missing `IO_WAIT`-cycle transfer, a bad `io_addr[1:0]` during one transfer, or a byte on the wrong lane of `cpu_rdata` in the ready cycle.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int LANES  = DW / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int WORD_W = AW - 2;
  localparam int PAIR_W = AW - 3;

  typedef enum logic [1:0] {
    DEV_8  = 2'b00,
    DEV_16 = 2'b01,
    DEV_32 = 2'b10
  } dev_size_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MEM,
    ST_IO
  } seq_state_e;

  typedef struct packed {
    logic [WORD_W-1:0] waddr;
    logic              we;
    logic [1:0]        size;
    logic [LANES-1:0]  be;
    logic [DW-1:0]     wdata;
  } req_t;

  function automatic logic [DW-1:0] lanes_to_bits(input logic [LANES-1:0] l);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{l[i]}};
    return m;
  endfunction
endpackage

// File: rtl/dbuf_pair_latch.sv
module dbuf_pair_latch
  import dbuf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_en,
  input  logic [PAIR_W-1:0] fill_tag,
  input  logic [DW-1:0]     fill_word0,
  input  logic [DW-1:0]     fill_word1,
  input  logic              inval_en,
  input  logic [PAIR_W-1:0] inval_tag,
  input  logic [PAIR_W-1:0] look_tag,
  input  logic              look_half,
  output logic              hit,
  output logic [DW-1:0]     hit_word
);
  logic              valid_q, valid_d;
  logic [PAIR_W-1:0] tag_q;
  logic [DW-1:0]     word0_q, word1_q;

  always_comb begin
    valid_d = valid_q;
    if (inval_en && (inval_tag == tag_q)) valid_d = 1'b0;
    if (fill_en) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q   <= fill_tag;
      word0_q <= fill_word0;
      word1_q <= fill_word1;
    end
  end

  assign hit      = valid_q && (tag_q == look_tag);
  assign hit_word = look_half ? word1_q : word0_q;
endmodule

// File: rtl/dbuf_lane_steer.sv
module dbuf_lane_steer
  import dbuf_pkg::*;
(
  input  logic [1:0]       size,
  input  logic [LANES-1:0] pend,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    io_rdata,
  output logic [LANES-1:0] lanes,
  output logic [OFF_W-1:0] off,
  output logic [DW-1:0]    placed,
  output logic [DW-1:0]    io_wdata
);
  logic [OFF_W-1:0] low;
  logic [DW-1:0]    keep;

  always_comb begin
    low = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) low = OFF_W'(i);
    end
  end

  always_comb begin
    unique case (dev_size_e'(size))
      DEV_8: begin
        off   = low;
        lanes = LANES'(1) << low;
        keep  = DW'(32'h0000_00FF);
      end
      DEV_16: begin
        off   = {low[OFF_W-1], 1'b0};
        lanes = low[OFF_W-1] ? 4'b1100 : 4'b0011;
        keep  = DW'(32'h0000_FFFF);
      end
      default: begin
        off   = '0;
        lanes = '1;
        keep  = '1;
      end
    endcase
  end

  assign placed   = (io_rdata & keep) << {off, 3'b000};
  assign io_wdata = wdata >> {off, 3'b000};
endmodule

// File: rtl/dbuf_seq.sv
module dbuf_seq
  import dbuf_pkg::*;
#(
  parameter int MEM_WAIT = 3,
  parameter int IO_WAIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_io,
  input  logic [1:0]        cpu_size,
  input  logic [WORD_W-1:0] cpu_addr,
  input  logic [LANES-1:0]  cpu_be,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              hit,
  input  logic [DW-1:0]     hit_word,
  input  logic [DW-1:0]     mem_rdata0,
  input  logic [DW-1:0]     mem_rdata1,
  input  logic [LANES-1:0]  st_lanes,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [DW-1:0]     st_placed,
  output logic [1:0]        st_size,
  output logic [LANES-1:0]  st_pend,
  output logic [DW-1:0]     st_wdata,
  output logic              fill_en,
  output logic [PAIR_W-1:0] fill_tag,
  output logic              inval_en,
  output logic              cpu_rdy,
  output logic [DW-1:0]     cpu_rdata,
  output logic              mem_cyc,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DW-1:0]     mem_wdata,
  output logic              io_cyc,
  output logic              io_we,
  output logic [AW-1:0]     io_addr
);
  localparam int MAX_WAIT = (MEM_WAIT > IO_WAIT) ? MEM_WAIT : IO_WAIT;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] MEM_LOAD = CNT_W'(MEM_WAIT - 1);
  localparam logic [CNT_W-1:0] IO_LOAD  = CNT_W'(IO_WAIT - 1);

  seq_state_e       state_q, state_d;
  logic             rdy_q, rdy_d;
  req_t             req_q, req_d;
  logic             req_en;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [LANES-1:0] pend_q, pend_d;
  logic [DW-1:0]    acc_q, acc_d;
  logic [DW-1:0]    rdata_q, rdata_d;
  logic [DW-1:0]    acc_new;
  logic [LANES-1:0] pend_left;

  assign acc_new   = acc_q | (st_placed & lanes_to_bits(st_lanes & req_q.be));
  assign pend_left = pend_q & ~st_lanes;

  always_comb begin
    state_d  = state_q;
    rdy_d    = 1'b0;
    req_d    = req_q;
    req_en   = 1'b0;
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    acc_d    = acc_q;
    rdata_d  = rdata_q;
    fill_en  = 1'b0;
    inval_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cpu_req) begin
          req_en = 1'b1;
          req_d  = '{waddr: cpu_addr, we: cpu_we, size: cpu_size,
                     be: cpu_be, wdata: cpu_wdata};
          if (cpu_io) begin
            state_d = ST_IO;
            cnt_d   = IO_LOAD;
            pend_d  = cpu_be;
            acc_d   = '0;
          end else if (cpu_we) begin
            inval_en = 1'b1;
            state_d  = ST_MEM;
            cnt_d    = MEM_LOAD;
          end else if (hit) begin
            rdy_d   = 1'b1;
            rdata_d = hit_word;
          end else begin
            state_d = ST_MEM;
            cnt_d   = MEM_LOAD;
          end
        end
      end
      ST_MEM: begin
        if (cnt_q == '0) begin
          rdy_d   = 1'b1;
          state_d = ST_IDLE;
          if (!req_q.we) begin
            fill_en = 1'b1;
            rdata_d = req_q.waddr[0] ? mem_rdata1 : mem_rdata0;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_IO: begin
        if (cnt_q == '0) begin
          acc_d  = acc_new;
          pend_d = pend_left;
          if (pend_left == '0) begin
            rdy_d   = 1'b1;
            rdata_d = acc_new;
            state_d = ST_IDLE;
          end else begin
            cnt_d = IO_LOAD;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_en) req_q <= req_d;
    if (state_d != ST_IDLE || state_q != ST_IDLE) cnt_q <= cnt_d;
    if (req_en || state_q == ST_IO) begin
      pend_q <= pend_d;
      acc_q  <= acc_d;
    end
    if (rdy_d) rdata_q <= rdata_d;
  end

  assign fill_tag  = req_q.waddr[WORD_W-1:1];
  assign st_size   = req_q.size;
  assign st_pend   = pend_q;
  assign st_wdata  = req_q.wdata;
  assign cpu_rdy   = rdy_q;
  assign cpu_rdata = rdata_q;
  assign mem_cyc   = (state_q == ST_MEM);
  assign mem_we    = mem_cyc && req_q.we;
  assign mem_addr  = req_q.waddr;
  assign mem_be    = req_q.be;
  assign mem_wdata = req_q.wdata;
  assign io_cyc    = (state_q == ST_IO);
  assign io_we     = io_cyc && req_q.we;
  assign io_addr   = {req_q.waddr, st_off};
endmodule

// File: rtl/dbuf_bus_bridge.sv
module dbuf_bus_bridge
  import dbuf_pkg::*;
#(
  parameter int MEM_WAIT = 3,
  parameter int IO_WAIT  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_we,
  input  logic        cpu_io,
  input  logic [1:0]  cpu_size,
  input  logic [31:2] cpu_addr,
  input  logic [3:0]  cpu_be,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        cpu_rdy,
  output logic        mem_cyc,
  output logic        mem_we,
  output logic [31:2] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata0,
  input  logic [31:0] mem_rdata1,
  output logic        io_cyc,
  output logic        io_we,
  output logic [31:0] io_addr,
  output logic [31:0] io_wdata,
  input  logic [31:0] io_rdata
);
  logic              hit;
  logic [DW-1:0]     hit_word;
  logic              fill_en, inval_en;
  logic [PAIR_W-1:0] fill_tag;
  logic [1:0]        st_size;
  logic [LANES-1:0]  st_pend, st_lanes;
  logic [OFF_W-1:0]  st_off;
  logic [DW-1:0]     st_wdata, st_placed;

  dbuf_pair_latch u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .fill_word0 (mem_rdata0),
    .fill_word1 (mem_rdata1),
    .inval_en   (inval_en),
    .inval_tag  (cpu_addr[31:3]),
    .look_tag   (cpu_addr[31:3]),
    .look_half  (cpu_addr[2]),
    .hit        (hit),
    .hit_word   (hit_word)
  );

  dbuf_lane_steer u_steer (
    .size     (st_size),
    .pend     (st_pend),
    .wdata    (st_wdata),
    .io_rdata (io_rdata),
    .lanes    (st_lanes),
    .off      (st_off),
    .placed   (st_placed),
    .io_wdata (io_wdata)
  );

  dbuf_seq #(.MEM_WAIT(MEM_WAIT), .IO_WAIT(IO_WAIT)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_io     (cpu_io),
    .cpu_size   (cpu_size),
    .cpu_addr   (cpu_addr),
    .cpu_be     (cpu_be),
    .cpu_wdata  (cpu_wdata),
    .hit        (hit),
    .hit_word   (hit_word),
    .mem_rdata0 (mem_rdata0),
    .mem_rdata1 (mem_rdata1),
    .st_lanes   (st_lanes),
    .st_off     (st_off),
    .st_placed  (st_placed),
    .st_size    (st_size),
    .st_pend    (st_pend),
    .st_wdata   (st_wdata),
    .fill_en    (fill_en),
    .fill_tag   (fill_tag),
    .inval_en   (inval_en),
    .cpu_rdy    (cpu_rdy),
    .cpu_rdata  (cpu_rdata),
    .mem_cyc    (mem_cyc),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_be     (mem_be),
    .mem_wdata  (mem_wdata),
    .io_cyc     (io_cyc),
    .io_we      (io_we),
    .io_addr    (io_addr)
  );
endmodule

// File: rtl/dbuf_bus_bridge_chk.sv
module dbuf_bus_bridge_chk #(
  parameter int MEM_WAIT = 3,
  parameter int IO_WAIT  = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpu_req,
  input logic        cpu_rdy,
  input logic        mem_cyc,
  input logic        mem_we,
  input logic        io_cyc,
  input logic        io_we,
  input logic [31:2] io_word
);
  logic [15:0] mem_run, io_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_run <= '0;
      io_run  <= '0;
    end else begin
      mem_run <= mem_cyc ? mem_run + 16'd1 : 16'd0;
      io_run  <= io_cyc ? io_run + 16'd1 : 16'd0;
    end
  end

  assert_bus_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_cyc && io_cyc));

  assert_rdy_has_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdy |-> ($past(cpu_req) || $past(mem_cyc) || $past(io_cyc)));

  assert_mem_end_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cyc) |-> cpu_rdy);

  assert_mem_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cyc |-> (mem_run < 16'(MEM_WAIT)));

  assert_io_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    io_cyc |-> (io_run < 16'(4 * IO_WAIT)));

  assert_io_end_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_cyc) |-> cpu_rdy);

  assert_io_same_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_cyc && $past(io_cyc)) |-> $stable(io_word));

  assert_mem_we_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_cyc);

  assert_io_we_window_R10: assert property (@(posedge clk) disable iff (!rst_n)
    io_we |-> io_cyc);
endmodule

bind dbuf_bus_bridge dbuf_bus_bridge_chk #(.MEM_WAIT(MEM_WAIT), .IO_WAIT(IO_WAIT)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cpu_req (cpu_req),
  .cpu_rdy (cpu_rdy),
  .mem_cyc (mem_cyc),
  .mem_we  (mem_we),
  .io_cyc  (io_cyc),
  .io_we   (io_we),
  .io_word (io_addr[31:2])
);

// File: tb/dbuf_bus_bridge_tb.sv
`timescale 1ns/1ps
module dbuf_bus_bridge_tb;
  localparam int MEM_WAIT = 3;
  localparam int IO_WAIT  = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we, cpu_io;
  logic [1:0]  cpu_size;
  logic [31:2] cpu_addr;
  logic [3:0]  cpu_be;
  logic [31:0] cpu_wdata, cpu_rdata;
  logic        cpu_rdy, mem_cyc, mem_we, io_cyc, io_we;
  logic [31:2] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, mem_rdata0, mem_rdata1;
  logic [31:0] io_addr, io_wdata, io_rdata;

  int checks   = 0;
  int failures = 0;
  bit         m_valid = 1'b0;
  logic [28:0] m_tag  = '0;

  always #2 clk = ~clk;

  function automatic logic [31:0] bank_word(input logic [28:0] p, input logic b);
    return ({p, b, 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

  function automatic logic [31:0] io_word(input logic [31:0] a);
    return (a ^ 32'h1357_9BDF) * 32'h85EB_CA77;
  endfunction

  function automatic logic [31:0] bytes_of(input logic [3:0] l);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[8*i +: 8] = {8{l[i]}};
    return m;
  endfunction

  assign mem_rdata0 = bank_word(mem_addr[31:3], 1'b0);
  assign mem_rdata1 = bank_word(mem_addr[31:3], 1'b1);
  assign io_rdata   = io_word(io_addr);

  dbuf_bus_bridge #(.MEM_WAIT(MEM_WAIT), .IO_WAIT(IO_WAIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_io(cpu_io),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_rdy(cpu_rdy), .mem_cyc(mem_cyc), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_rdata0(mem_rdata0), .mem_rdata1(mem_rdata1), .io_cyc(io_cyc), .io_we(io_we),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic access(input bit we, input bit io, input logic [1:0] size,
                        input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input string tag_in);
    string       tag = tag_in;
    logic [28:0] pair = addr[31:3];
    bit          hit = m_valid && (m_tag == pair);
    int          n = 0;
    logic [1:0]  offs[4];
    logic [3:0]  lns[4];
    logic [31:0] keep;
    logic [3:0]  p = be;
    logic [31:0] exp_rd = '0;
    int exp_lat, exp_mcyc, exp_icyc;
    int cyc = 1, mcyc = 0, icyc = 0, merr = 0, ierr = 0, both = 0;

    keep = (size == 2'b00) ? 32'hFF : (size == 2'b01) ? 32'hFFFF : 32'hFFFF_FFFF;
    while (p != 0 && n < 4) begin
      int l = 0;
      for (int i = 3; i >= 0; i--) if (p[i]) l = i;
      if (size == 2'b00) begin offs[n] = 2'(l); lns[n] = 4'b0001 << l; end
      else if (size == 2'b01) begin
        offs[n] = (l >= 2) ? 2'b10 : 2'b00;
        lns[n]  = (l >= 2) ? 4'b1100 : 4'b0011;
      end else begin offs[n] = 2'b00; lns[n] = 4'hF; end
      p = p & ~lns[n];
      n++;
    end

    if (io) begin
      exp_lat = n * IO_WAIT + 1; exp_mcyc = 0; exp_icyc = n * IO_WAIT;
      for (int k = 0; k < n; k++)
        exp_rd |= ((io_word({addr[31:2], offs[k]}) & keep) << (8 * offs[k]))
                  & bytes_of(lns[k] & be);
    end else if (we) begin
      exp_lat = MEM_WAIT + 1; exp_mcyc = MEM_WAIT; exp_icyc = 0;
      if (m_valid && m_tag == pair) m_valid = 1'b0;
    end else begin
      exp_lat = hit ? 1 : MEM_WAIT + 1; exp_mcyc = hit ? 0 : MEM_WAIT; exp_icyc = 0;
      exp_rd = bank_word(pair, addr[2]);
      if (hit && tag == "R2") tag = "R3";
      m_valid = 1'b1; m_tag = pair;
    end

    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_io = io; cpu_size = size;
    cpu_addr = addr[31:2]; cpu_be = be; cpu_wdata = wd;
    @(negedge clk);
    cpu_req = 1'b0;
    while (!cpu_rdy && cyc < 1000) begin
      if (mem_cyc && io_cyc) both++;
      if (mem_cyc) begin
        mcyc++;
        if (mem_addr != addr[31:2] || mem_we != we) merr++;
        if (we && (mem_be != be || mem_wdata != wd)) merr++;
      end
      if (io_cyc) begin
        int idx = icyc / IO_WAIT;
        if (idx >= n || io_addr != {addr[31:2], offs[idx]} || io_we != we) ierr++;
        else if (we && ((io_wdata & keep) != ((wd >> (8 * offs[idx])) & keep))) ierr++;
        icyc++;
      end
      @(negedge clk);
      cyc++;
    end

    chk(cpu_rdy == 1'b1, tag, "ready seen", 32'(cpu_rdy), 32'd1);
    chk(cyc == exp_lat, tag, "latency", 32'(cyc), 32'(exp_lat));
    chk(mcyc == exp_mcyc, tag, "memory cycles", 32'(mcyc), 32'(exp_mcyc));
    chk(both == 0, "R12", "bus overlap", 32'(both), 32'd0);
    if (io) begin
      chk(icyc == exp_icyc, "R9", "io cycles", 32'(icyc), 32'(exp_icyc));
      chk(ierr == 0, we ? "R10" : tag, "io transfer fields", 32'(ierr), 32'd0);
    end else begin
      chk(merr == 0, we ? "R5" : "R2", "memory fields", 32'(merr), 32'd0);
    end
    if (!we) chk(cpu_rdata == exp_rd, tag, "read data", cpu_rdata, exp_rd);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] pa, pb, pc;
    void'($urandom(32'd715));
    rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_io = 1'b0; cpu_size = 2'b00;
    cpu_addr = '0; cpu_be = 4'hF; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!cpu_rdy && !mem_cyc && !io_cyc, "R1", "outputs in reset",
        {29'd0, cpu_rdy, mem_cyc, io_cyc}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cpu_rdy && !mem_cyc && !io_cyc, "R1", "outputs after reset",
        {29'd0, cpu_rdy, mem_cyc, io_cyc}, 32'd0);

    pa = 32'h0001_0040; pb = 32'h0001_0088; pc = 32'h0002_0010;
    access(1'b0, 1'b0, 2'b00, pa,       4'hF, '0, "R1");
    access(1'b0, 1'b0, 2'b00, pa | 4,   4'hF, '0, "R3");
    access(1'b0, 1'b0, 2'b00, pa,       4'hF, '0, "R3");
    access(1'b1, 1'b0, 2'b00, pa | 4,   4'h5, 32'hCAFE_F00D, "R5");
    access(1'b0, 1'b0, 2'b00, pa,       4'hF, '0, "R5");
    access(1'b0, 1'b0, 2'b00, pb | 4,   4'hF, '0, "R2");
    access(1'b0, 1'b0, 2'b00, pa | 4,   4'hF, '0, "R4");
    access(1'b0, 1'b0, 2'b00, pb,       4'hF, '0, "R4");
    access(1'b1, 1'b0, 2'b00, pc,       4'hF, 32'h1234_5678, "R5");
    access(1'b0, 1'b0, 2'b00, pb | 4,   4'hF, '0, "R5");
    access(1'b0, 1'b1, 2'b00, 32'h0000_4010, 4'hF, '0, "R6");
    access(1'b0, 1'b1, 2'b00, 32'h0000_4020, 4'h4, '0, "R6");
    access(1'b0, 1'b1, 2'b01, 32'h0000_4030, 4'hF, '0, "R7");
    access(1'b0, 1'b1, 2'b01, 32'h0000_4040, 4'h8, '0, "R7");
    access(1'b0, 1'b1, 2'b10, 32'h0000_4050, 4'hF, '0, "R8");
    access(1'b0, 1'b1, 2'b11, 32'h0000_4054, 4'h6, '0, "R8");
    access(1'b1, 1'b1, 2'b00, 32'h0000_4060, 4'h6, 32'hA1B2_C3D4, "R10");
    access(1'b1, 1'b1, 2'b01, 32'h0000_4070, 4'hC, 32'h5566_7788, "R10");
    access(1'b0, 1'b0, 2'b00, pb,       4'hF, '0, "R11");

    for (int it = 0; it < 400; it++) begin
      int          kind = int'($urandom % 6);
      logic [1:0]  sz   = 2'($urandom % 3);
      logic [3:0]  be   = 4'($urandom % 15 + 1);
      logic [31:0] wd   = $urandom;
      logic [31:0] ma   = 32'h0001_0000 + 32'(($urandom % 4) * 8) + 32'(($urandom % 2) * 4);
      logic [31:0] ia   = 32'h0000_4000 + 32'(($urandom % 64) * 4);
      string       itag = (sz == 2'b00) ? "R6" : (sz == 2'b01) ? "R7" : "R8";
      case (kind)
        0, 1: access(1'b0, 1'b0, 2'b00, ma, 4'hF, '0, "R2");
        2:    access(1'b1, 1'b0, 2'b00, ma, be, wd, "R5");
        3, 4: access(1'b0, 1'b1, sz, ia, be, '0, itag);
        default: access(1'b1, 1'b1, sz, ia, be, wd, "R10");
      endcase
    end

    summary();
    $finish;
  end
endmodule